// File: doc/BRIEF.md
# Nonvolatile Write-Protect Supervisor

This block sits between the decoded control strobes of a battery-free shadowed memory and the engine that copies the volatile array into nonvolatile cells (a store) or back again (a recall). It decides, cycle by cycle, whether such a transfer may begin. Its inputs are four active-low strobes (select, write, read/output, nonvolatile), a digital supply-good flag and a power-up reset. Its outputs are one-cycle start pulses for store and recall and an inhibit flag that shuts off every memory operation.

After the supply becomes good, two delay counters run. The shorter one gates volatile-array access. The longer one gates nonvolatile transfers. When the longer one expires, the block emits one automatic recall, whatever the strobes are doing. A strobe combination only counts once it has been held for a minimum number of clock samples. Each held combination yields a single pulse. A store also requires a volatile write since the last transfer. When the supply drops, everything is cut off at once.

The control is built from three small state machines. The power sequencer has the states PWR_OFF, PWR_RAM_WAIT, PWR_NV_WAIT and PWR_READY. It moves OFF→RAM_WAIT when supply is sampled good, RAM_WAIT→NV_WAIT when the short delay ends, NV_WAIT→READY when the long delay ends (this move emits the automatic recall), and from any state back to OFF on supply loss. Each pulse qualifier (one for store, one for recall) has the states Q_IDLE, Q_COUNT, Q_FIRED and Q_BLOCKED. Its transitions are:
- IDLE→COUNT when the pattern is seen while transfers are enabled.
- COUNT→FIRED when the width is met; this move emits the pulse.
- COUNT→IDLE when the pattern breaks.
- IDLE→BLOCKED or COUNT→BLOCKED when the pattern is seen while transfers are disabled.
- FIRED→IDLE and BLOCKED→IDLE only on release.

The arming latch has the states ARM_EMPTY and ARM_SET. A volatile write moves it EMPTY→SET. Any transfer start or inhibit moves it back to EMPTY.

Top module: `nv_guard`

## Requirements
- R1: While power-up reset is asserted or supply_ok is low, inhibit is 1 and neither store_go nor recall_go is ever 1.
- R2: inhibit stays 1 until supply_ok has been sampled high on RAM_DLY+1 consecutive rising edges; it is 0 in the cycle after that edge.
- R3: After supply_ok has been sampled high on NV_DLY+1 consecutive rising edges, recall_go is 1 for exactly the following cycle, whatever the strobe levels.
- R4: The store pattern is sel_n=0, wr_n=0, nvm_n=0 and oe_n=1. When it is sampled on MIN_W consecutive edges while transfers are enabled and the latch is armed, store_go is 1 for the one cycle after the MIN_W-th edge.
- R5: The recall pattern is sel_n=0, oe_n=0, nvm_n=0 and wr_n=1. When it is sampled on MIN_W consecutive edges while transfers are enabled, recall_go is 1 for the one cycle after the MIN_W-th edge.
- R6: A store or recall pattern held for fewer than MIN_W edges produces no pulse.
- R7: A pattern held for any length produces at most one pulse; another pulse needs the pattern to be released and applied again.
- R8: A volatile write is sel_n=0, wr_n=0, nvm_n=1 while inhibit is 0, and it arms the latch. A qualified store pattern with the latch empty gives no store_go.
- R9: Any store_go or recall_go empties the latch on the next edge. If a volatile write is sampled on that same edge, emptying wins.
- R10: A pattern present while transfers are not yet enabled is discarded. If it is held across the moment of enabling, it yields no pulse until it is released.
- R11: When supply_ok falls, inhibit goes to 1 and both pulses go to 0 in the same cycle, and the whole power-up delay sequence restarts when supply returns.
- R12: With oe_n=0, no store starts: all four strobes low gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | power-up reset, active low |
| supply_ok | input | 1 | supply above sense threshold |
| sel_n | input | 1 | chip select strobe, active low |
| wr_n | input | 1 | write strobe, active low |
| oe_n | input | 1 | output/read strobe, active low |
| nvm_n | input | 1 | nonvolatile access strobe, active low |
| store_go | output | 1 | one-cycle store start |
| recall_go | output | 1 | one-cycle recall start |
| inhibit | output | 1 | all memory operations blocked |

## Verification
The two functions that can coincide are arming by a volatile write and disarming by a transfer start. The bench provokes this by holding a volatile write from a few cycles before the long delay ends until after the automatic recall pulse, so that the write is sampled on the very edge at which the recall empties the latch. It judges the outcome at the ports: a correctly timed store pattern that follows must produce no store_go, and a fresh write followed by the same pattern must then produce one at the predicted cycle.

// File: rtl/nvg_pkg.sv
`timescale 1ns/1ps
package nvg_pkg;

    typedef enum logic [1:0] {
        PWR_OFF      = 2'd0,
        PWR_RAM_WAIT = 2'd1,
        PWR_NV_WAIT  = 2'd2,
        PWR_READY    = 2'd3
    } pwr_state_t;

    typedef enum logic [1:0] {
        Q_IDLE    = 2'd0,
        Q_COUNT   = 2'd1,
        Q_FIRED   = 2'd2,
        Q_BLOCKED = 2'd3
    } qual_state_t;

    typedef enum logic {
        ARM_EMPTY = 1'b0,
        ARM_SET   = 1'b1
    } arm_state_t;

endpackage

// File: rtl/nvg_power_seq.sv
`timescale 1ns/1ps
module nvg_power_seq
    import nvg_pkg::*;
#(
    parameter int RAM_DLY = 8,
    parameter int NV_DLY  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic ram_ok,
    output logic nv_ok,
    output logic auto_recall
);

    localparam int CW = $clog2(NV_DLY + 1);
    localparam logic [CW-1:0] RAM_LAST = CW'(RAM_DLY - 1);
    localparam logic [CW-1:0] NV_LAST  = CW'(NV_DLY - 1);

    pwr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          auto_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!supply_ok) begin
            state_d = PWR_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PWR_OFF: begin
                    state_d = PWR_RAM_WAIT;
                    cnt_d   = '0;
                end
                PWR_RAM_WAIT: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == RAM_LAST) state_d = PWR_NV_WAIT;
                end
                PWR_NV_WAIT: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == NV_LAST) state_d = PWR_READY;
                end
                PWR_READY: begin
                    cnt_d = cnt_q;
                end
                default: state_d = PWR_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered output: the single automatic recall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) auto_q <= 1'b0;
        else        auto_q <= (state_q == PWR_NV_WAIT) && (state_d == PWR_READY);
    end

    assign ram_ok      = supply_ok && ((state_q == PWR_NV_WAIT) || (state_q == PWR_READY));
    assign nv_ok       = supply_ok && (state_q == PWR_READY);
    assign auto_recall = supply_ok && auto_q;

endmodule

// File: rtl/nvg_pulse_qual.sv
`timescale 1ns/1ps
module nvg_pulse_qual
    import nvg_pkg::*;
#(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pattern,
    input  logic enable,
    output logic fire
);

    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

    qual_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          fire_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            Q_IDLE: begin
                cnt_d = '0;
                if (pattern && !enable) begin
                    state_d = Q_BLOCKED;
                end else if (pattern) begin
                    cnt_d = CW'(1);
                    if (MIN_W <= 1) state_d = Q_FIRED;
                    else            state_d = Q_COUNT;
                end
            end
            Q_COUNT: begin
                if (!pattern) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end else if (!enable) begin
                    state_d = Q_BLOCKED;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = Q_FIRED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            Q_FIRED: begin
                if (!pattern) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end
            end
            Q_BLOCKED: begin
                if (!pattern) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= (state_q != Q_FIRED) && (state_d == Q_FIRED);
    end

    assign fire = fire_q;

endmodule

// File: rtl/nvg_arm_latch.sv
`timescale 1ns/1ps
module nvg_arm_latch
    import nvg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ram_write,
    input  logic xfer_start,
    input  logic blocked,
    output logic armed
);

    arm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_EMPTY: if (ram_write && !xfer_start && !blocked) state_d = ARM_SET;
            ARM_SET:   if (xfer_start || blocked)                state_d = ARM_EMPTY;
            default:   state_d = ARM_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_EMPTY;
        else        state_q <= state_d;
    end

    assign armed = (state_q == ARM_SET);

endmodule

// File: rtl/nv_guard.sv
`timescale 1ns/1ps
module nv_guard #(
    parameter int RAM_DLY = 8,
    parameter int NV_DLY  = 40,
    parameter int MIN_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic sel_n,
    input  logic wr_n,
    input  logic oe_n,
    input  logic nvm_n,
    output logic store_go,
    output logic recall_go,
    output logic inhibit
);

    localparam int N_QUAL = 2;
    localparam int IDX_ST = 0;
    localparam int IDX_RC = 1;

    logic              ram_ok, nv_ok, auto_rc;
    logic              armed;
    logic [N_QUAL-1:0] pat, fire;
    logic              ram_write;

    assign pat[IDX_ST] = !sel_n && !wr_n && !nvm_n &&  oe_n;
    assign pat[IDX_RC] = !sel_n && !oe_n && !nvm_n &&  wr_n;
    assign ram_write   = !sel_n && !wr_n &&  nvm_n && ram_ok;

    nvg_power_seq #(
        .RAM_DLY (RAM_DLY),
        .NV_DLY  (NV_DLY)
    ) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .ram_ok      (ram_ok),
        .nv_ok       (nv_ok),
        .auto_recall (auto_rc)
    );

    for (genvar g = 0; g < N_QUAL; g++) begin : g_qual
        nvg_pulse_qual #(
            .MIN_W (MIN_W)
        ) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .pattern (pat[g]),
            .enable  (nv_ok),
            .fire    (fire[g])
        );
    end

    nvg_arm_latch u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ram_write  (ram_write),
        .xfer_start (store_go || recall_go),
        .blocked    (!ram_ok),
        .armed      (armed)
    );

    assign store_go  = fire[IDX_ST] && armed && nv_ok;
    assign recall_go = (fire[IDX_RC] && nv_ok) || auto_rc;
    assign inhibit   = !ram_ok;

endmodule

// File: rtl/nv_guard_chk.sv
`timescale 1ns/1ps
module nv_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic oe_n,
    input logic store_go,
    input logic recall_go,
    input logic inhibit
);

    // R11: supply loss cuts everything in the same cycle
    a_r11_supply_cut: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (inhibit && !store_go && !recall_go));

    // R1: no transfer start while operations are inhibited
    a_r1_quiet_when_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (!store_go && !recall_go));

    // R7: store pulse lasts a single cycle
    a_r7_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> !store_go);

    // R7: recall pulse lasts a single cycle
    a_r7_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |=> !recall_go);

    // R12: output strobe low on the qualifying edge blocks a store
    a_r12_oe_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!oe_n) |-> !store_go);

    // R4: store and recall never start together
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_go && recall_go));

endmodule

bind nv_guard nv_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .oe_n      (oe_n),
    .store_go  (store_go),
    .recall_go (recall_go),
    .inhibit   (inhibit)
);

// File: tb/nv_guard_test.sv
`timescale 1ns/1ps
module nv_guard_test;

    localparam int CLK_P   = 10;
    localparam int RAM_DLY = 8;
    localparam int NV_DLY  = 40;
    localparam int MIN_W   = 4;

    // strobe patterns {sel_n, wr_n, oe_n, nvm_n}
    localparam logic [3:0] B_IDLE   = 4'b1111;
    localparam logic [3:0] B_WRITE  = 4'b0011;
    localparam logic [3:0] B_STORE  = 4'b0010;
    localparam logic [3:0] B_RECALL = 4'b0100;
    localparam logic [3:0] B_ALLLOW = 4'b0000;

    logic clk = 1'b0;
    logic rst_n, supply_ok, sel_n, wr_n, oe_n, nvm_n;
    logic store_go, recall_go, inhibit;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int seen = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    typedef struct {
        bit    is_store;
        int    at;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    nv_guard #(
        .RAM_DLY (RAM_DLY),
        .NV_DLY  (NV_DLY),
        .MIN_W   (MIN_W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .oe_n      (oe_n),
        .nvm_n     (nvm_n),
        .store_go  (store_go),
        .recall_go (recall_go),
        .inhibit   (inhibit)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected pulses and compares kind and cycle
    task automatic take(input bit is_store);
        exp_t e;
        seen++;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s unexpected %s pulse at cycle %0d, expected none",
                     cur_req, is_store ? "store" : "recall", cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.is_store != is_store || e.at != cyc) begin
                errors++;
                $display("FAIL %s got %s at %0d, expected %s at %0d", e.tag,
                         is_store ? "store" : "recall", cyc,
                         e.is_store ? "store" : "recall", e.at);
            end
        end
    endtask

    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (rst_n && store_go)  take(1'b1);
        if (rst_n && recall_go) take(1'b0);
    end

    task automatic push(input bit is_store, input int at, input string tag);
        exp_t e;
        e.is_store = is_store;
        e.at = at;
        e.tag = tag;
        exp_q.push_back(e);
        pushed++;
    endtask

    task automatic apply(input logic [3:0] b);
        {sel_n, wr_n, oe_n, nvm_n} = b;
    endtask

    // drive a pattern for n edges; kind 0 none, 1 store, 2 recall expected
    task automatic hold(input logic [3:0] b, input int n, input int kind, input string tag);
        int t0;
        @(negedge clk);
        cur_req = tag;
        apply(b);
        t0 = cyc;
        if (kind == 1) push(1'b1, t0 + MIN_W, tag);
        if (kind == 2) push(1'b0, t0 + MIN_W, tag);
        repeat (n) @(negedge clk);
        apply(B_IDLE);
    endtask

    task automatic settle(input string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (seen != pushed || exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s pulses seen %0d, expected %0d", tag, seen, pushed);
        end
    endtask

    task automatic probe_at(input int target, input logic want, input string tag);
        do begin
            @(posedge clk);
            #(CLK_P/4);
        end while (cyc < target);
        checks++;
        if (inhibit !== want) begin
            errors++;
            $display("FAIL %s inhibit at cycle %0d is %b, expected %b", tag, cyc, inhibit, want);
        end
    endtask

    task automatic to_cyc(input int target);
        @(negedge clk);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, expected run to end");
        finish_run();
    end

    initial begin
        int c0;
        rst_n = 1'b0;
        supply_ok = 1'b0;
        apply(B_IDLE);
        repeat (4) @(negedge clk);
        checks++;
        if (inhibit !== 1'b1 || store_go !== 1'b0 || recall_go !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs inh=%b st=%b rc=%b, expected 1 0 0",
                     inhibit, store_go, recall_go);
        end
        rst_n = 1'b1;
        hold(B_RECALL, 6, 0, "R1");
        settle("R1");

        // first power-up: recall strobes held early, then a write colliding with the auto recall
        @(negedge clk);
        cur_req = "R3";
        supply_ok = 1'b1;
        apply(B_RECALL);
        c0 = cyc;
        push(1'b0, c0 + NV_DLY + 1, "R3");
        probe_at(c0 + RAM_DLY, 1'b1, "R2");
        probe_at(c0 + RAM_DLY + 1, 1'b0, "R2");
        @(negedge clk);
        apply(B_IDLE);
        to_cyc(c0 + NV_DLY - 2);
        cur_req = "R9";
        apply(B_WRITE);
        to_cyc(c0 + NV_DLY + 2);
        apply(B_IDLE);
        settle("R3");
        hold(B_STORE, 6, 0, "R9");     // write coincided with recall start: latch empty
        settle("R9");

        // armed store
        hold(B_WRITE, 1, 0, "R8");
        hold(B_STORE, 6, 1, "R4");
        settle("R4");
        hold(B_STORE, 6, 0, "R8");     // store emptied the latch
        settle("R8");

        // recall, long hold, then store must be refused
        hold(B_WRITE, 1, 0, "R8");
        hold(B_RECALL, 12, 2, "R7");
        settle("R7");
        hold(B_STORE, 6, 0, "R9");
        settle("R9");

        // width boundary
        hold(B_WRITE, 1, 0, "R8");
        hold(B_STORE, MIN_W - 1, 0, "R6");
        settle("R6");
        hold(B_STORE, MIN_W, 1, "R6");
        settle("R6");
        hold(B_RECALL, MIN_W - 1, 0, "R6");
        settle("R6");
        hold(B_RECALL, MIN_W, 2, "R5");
        settle("R5");

        // output strobe low blocks store
        hold(B_WRITE, 1, 0, "R8");
        hold(B_ALLLOW, 8, 0, "R12");
        settle("R12");
        hold(B_STORE, 5, 1, "R12");    // latch still armed after the refused combination
        settle("R12");

        // supply loss mid-pattern
        hold(B_WRITE, 1, 0, "R8");
        @(negedge clk);
        cur_req = "R11";
        apply(B_STORE);
        repeat (2) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        checks++;
        if (inhibit !== 1'b1) begin
            errors++;
            $display("FAIL R11 inhibit %b after supply loss, expected 1", inhibit);
        end
        repeat (4) @(negedge clk);
        apply(B_IDLE);
        settle("R11");
        hold(B_RECALL, 6, 0, "R11");
        settle("R11");

        // second power-up: recall pattern held across enabling
        @(negedge clk);
        cur_req = "R10";
        supply_ok = 1'b1;
        apply(B_RECALL);
        c0 = cyc;
        push(1'b0, c0 + NV_DLY + 1, "R11");
        probe_at(c0 + RAM_DLY, 1'b1, "R11");
        to_cyc(c0 + NV_DLY + 6);
        apply(B_IDLE);
        settle("R10");
        hold(B_RECALL, MIN_W + 2, 2, "R10");
        settle("R10");

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 %0d expected pulses never seen, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule